// File: doc/BRIEF.md
# Jittered Current-Mode PWM Timer

This block times the switching cycle of a current-mode flyback controller. It runs from a fast system clock. At the start of every switching period it raises the gate request and emits a one-clock cycle-start pulse. It lowers the gate when the peak-current comparator trips. The comparator flag is asynchronous, so the block synchronizes it first. The block ignores that flag during a short blanking window after turn-on and before a minimum on time has passed. A maximum duty limit forces turn-off if no trip arrives.

The period length is not fixed. A triangular ramp moves it up and down around the nominal value by one step per switching cycle, which spreads the switching energy over neighbouring frequencies. A select input chooses between a low-frequency variant (60 kHz, ±4 kHz) and a high-frequency variant (115 kHz, ±8 kHz). A burst-inhibit input stops new cycles from starting, and the enable input stops switching at once.

Top module: `jit_pwm_timer`

## Requirements
- R1: While rst_ni is low, gate_o and start_o are 0 and off_o is 1.
- R2: The nominal period in clocks is floor(CLK_HZ/60000) when sel_hi_i=0 and floor(CLK_HZ/115000) when sel_hi_i=1. The first cycle after enable uses the nominal period.
- R3: The interval between successive start_o pulses equals nominal plus an offset. The offset starts at 0 and rises by STEP per started cycle until it reaches +DEV, where it is clamped and the direction reverses. It then falls by STEP until it reaches -DEV, where it is clamped and reverses again. DEV = (floor(CLK_HZ/(F-FD)) - floor(CLK_HZ/(F+FD)))/2. STEP = max(1, ceil(4*DEV/(F/250))).
- R4: start_o is high for exactly one clock at each cycle start, and gate_o rises in that same clock.
- R5: With no current trip, gate_o stays high for exactly floor(P*80/100) clocks of a cycle of period P.
- R6: trip_i passes through a two-flop synchronizer. If trip_i rises d clocks after start_o is observed, and no other limit applies, gate_o is high for d+3 clocks.
- R7: During the first ceil(300 ns*CLK_HZ) clocks of the on time, a synchronized trip has no effect.
- R8: gate_o never falls because of a trip before ceil(400 ns*CLK_HZ) clocks of on time. With trip_i held high, the on time is max(blank, min-on)+1 clocks.
- R9: While burst_i is high at a period boundary, no cycle starts, start_o stays 0 and gate_o stays low. The cycle already running completes. Once burst_i is released, a cycle starts on the next clock. The ramp does not advance during inhibited periods.
- R10: Dropping en_i forces gate_o low on the next clock and returns the ramp to offset 0, rising. Raising en_i starts a cycle on the next clock.
- R11: off_o is always the inverse of gate_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Switching enable |
| trip_i | input | 1 | Peak-current comparator flag, asynchronous |
| sel_hi_i | input | 1 | Frequency variant: 0 low, 1 high |
| burst_i | input | 1 | Inhibits new cycle starts |
| gate_o | output | 1 | Power switch gate request |
| start_o | output | 1 | One-clock pulse at each cycle start |
| off_o | output | 1 | High while the gate is low |

## Verification
The hardest state to reach from the ports is the clamp of the jitter ramp at both extremes, and only when the clamp coincides with trips that land inside the qualification window. The bench reaches it by running enough consecutive cycles in each variant to cover a full sweep. On each cycle it draws a random trip delay, which covers both late trips and trips that the blanking and minimum on time must mask. Directed segments hold the trip high across a boundary, insert a burst pause mid-sweep to show the ramp freezes, and disable mid-pulse to show the ramp restarts.

// File: rtl/jit_pwm_pkg.sv
package jit_pwm_pkg;
  typedef enum logic {VAR_LO = 1'b0, VAR_HI = 1'b1} variant_e;

  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/jit_pwm_sync.sv
module jit_pwm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/jit_pwm_ramp.sv
module jit_pwm_ramp
  import jit_pwm_pkg::*;
#(
  parameter int CW      = 12,
  parameter int PER_LO  = 1666,
  parameter int PER_HI  = 869,
  parameter int DEV_LO  = 111,
  parameter int DEV_HI  = 60,
  parameter int STEP_LO = 2,
  parameter int STEP_HI = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          step_i,
  input  logic          sel_hi_i,
  output logic [CW-1:0] period_o
);
  localparam int DEV_MAX = max2(DEV_LO, DEV_HI);
  localparam logic signed [CW:0] DEV_MAX_S = (CW+1)'(DEV_MAX);

  variant_e          var_sel;
  logic signed [CW:0] off_q, dev_s, stp_s, sum_up, sum_dn, sum;
  logic              up_q;
  logic [CW-1:0]     nom;

  always_comb begin
    var_sel = variant_e'(sel_hi_i);
    if (var_sel == VAR_HI) begin
      nom   = CW'(PER_HI);
      dev_s = (CW+1)'(DEV_HI);
      stp_s = (CW+1)'(STEP_HI);
    end else begin
      nom   = CW'(PER_LO);
      dev_s = (CW+1)'(DEV_LO);
      stp_s = (CW+1)'(STEP_LO);
    end
    sum_up   = off_q + stp_s;
    sum_dn   = off_q - stp_s;
    sum      = $signed({1'b0, nom}) + off_q;
    period_o = CW'(sum);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q <= '0;
      up_q  <= 1'b1;
    end else if (clr_i) begin
      off_q <= '0;
      up_q  <= 1'b1;
    end else if (step_i) begin
      if (up_q) begin
        if (sum_up >= dev_s) begin
          off_q <= dev_s;
          up_q  <= 1'b0;
        end else begin
          off_q <= sum_up;
        end
      end else begin
        if (sum_dn <= -dev_s) begin
          off_q <= -dev_s;
          up_q  <= 1'b1;
        end else begin
          off_q <= sum_dn;
        end
      end
    end
  end

  AST_RAMP_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (off_q <= DEV_MAX_S) && (off_q >= -DEV_MAX_S)); // R3
  AST_RAMP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !clr_i) |=> $stable(off_q)); // R3
endmodule

// File: rtl/jit_pwm_core.sv
module jit_pwm_core #(
  parameter int CW       = 12,
  parameter int QUAL     = 40,
  parameter int DUTY_PCT = 80
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          burst_i,
  input  logic          trip_i,
  input  logic [CW-1:0] period_i,
  output logic          gate_o,
  output logic          start_o,
  output logic          step_o
);
  localparam int PW = CW + 8;
  localparam logic [CW-1:0] QUAL_C = CW'(QUAL);

  logic          run_q, gate_q, start_q;
  logic [CW-1:0] cnt_q, per_q, dlim_q, dlim_nxt;
  logic [PW-1:0] prod;
  logic          last, launch, trip_ok, duty_end;

  always_comb begin
    prod     = {8'b0, period_i} * PW'(DUTY_PCT);
    dlim_nxt = CW'(prod / PW'(100));
    last     = run_q && (cnt_q == per_q - CW'(1));
    launch   = en_i && !burst_i && (!run_q || last);
    trip_ok  = trip_i && (cnt_q >= QUAL_C);
    duty_end = (cnt_q + CW'(1)) >= dlim_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0; gate_q <= 1'b0; start_q <= 1'b0;
      cnt_q <= '0; per_q <= '0; dlim_q <= '0;
    end else if (!en_i) begin
      run_q <= 1'b0; gate_q <= 1'b0; start_q <= 1'b0;
      cnt_q <= '0;
    end else if (launch) begin
      run_q   <= 1'b1;
      gate_q  <= 1'b1;
      start_q <= 1'b1;
      cnt_q   <= '0;
      per_q   <= period_i;
      dlim_q  <= dlim_nxt;
    end else if (last) begin
      run_q <= 1'b0; gate_q <= 1'b0; start_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      start_q <= 1'b0;
      if (run_q) begin
        cnt_q <= cnt_q + CW'(1);
        if (gate_q && (trip_ok || duty_end)) gate_q <= 1'b0;
      end
    end
  end

  assign gate_o  = gate_q;
  assign start_o = start_q;
  assign step_o  = launch;

  AST_DISABLE_GATE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !gate_q); // R10
  AST_BURST_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_i |=> !start_q); // R9
  AST_START_WITH_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |-> gate_q); // R4
  AST_START_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |=> !start_q); // R4
  AST_DUTY_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_q |-> (cnt_q < dlim_q)); // R5
  AST_MIN_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(gate_q) && $past(en_i)) |-> ($past(cnt_q) >= QUAL_C)); // R8
endmodule

// File: rtl/jit_pwm_timer.sv
module jit_pwm_timer
  import jit_pwm_pkg::*;
#(
  parameter int CLK_HZ      = 100_000_000,
  parameter int F_LO_HZ     = 60_000,
  parameter int F_HI_HZ     = 115_000,
  parameter int FD_LO_HZ    = 4_000,
  parameter int FD_HI_HZ    = 8_000,
  parameter int SWEEP_HZ    = 250,
  parameter int DUTY_PCT    = 80,
  parameter int BLANK_NS    = 300,
  parameter int MIN_ON_NS   = 400,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic trip_i,
  input  logic sel_hi_i,
  input  logic burst_i,
  output logic gate_o,
  output logic start_o,
  output logic off_o
);
  localparam int PER_LO  = CLK_HZ / F_LO_HZ;
  localparam int PER_HI  = CLK_HZ / F_HI_HZ;
  localparam int DEV_LO  = (CLK_HZ / (F_LO_HZ - FD_LO_HZ) - CLK_HZ / (F_LO_HZ + FD_LO_HZ)) / 2;
  localparam int DEV_HI  = (CLK_HZ / (F_HI_HZ - FD_HI_HZ) - CLK_HZ / (F_HI_HZ + FD_HI_HZ)) / 2;
  localparam int STEP_LO = max2(1, ceil_div(4 * DEV_LO, F_LO_HZ / SWEEP_HZ));
  localparam int STEP_HI = max2(1, ceil_div(4 * DEV_HI, F_HI_HZ / SWEEP_HZ));
  localparam int BLANK_C = ceil_div(BLANK_NS * (CLK_HZ / 1000), 1_000_000);
  localparam int MINON_C = ceil_div(MIN_ON_NS * (CLK_HZ / 1000), 1_000_000);
  localparam int QUAL    = max2(BLANK_C, MINON_C);
  localparam int CW      = $clog2(max2(PER_LO + DEV_LO, PER_HI + DEV_HI) + 1);

  logic          trip_s, launch;
  logic [CW-1:0] period;

  jit_pwm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(trip_i), .q_o(trip_s)
  );

  jit_pwm_ramp #(
    .CW(CW), .PER_LO(PER_LO), .PER_HI(PER_HI), .DEV_LO(DEV_LO),
    .DEV_HI(DEV_HI), .STEP_LO(STEP_LO), .STEP_HI(STEP_HI)
  ) u_ramp (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(!en_i), .step_i(launch),
    .sel_hi_i(sel_hi_i), .period_o(period)
  );

  jit_pwm_core #(.CW(CW), .QUAL(QUAL), .DUTY_PCT(DUTY_PCT)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .burst_i(burst_i),
    .trip_i(trip_s), .period_i(period), .gate_o(gate_o),
    .start_o(start_o), .step_o(launch)
  );

  assign off_o = ~gate_o;

  AST_OFF_MARKER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_o != gate_o); // R11
endmodule

// File: tb/jit_pwm_timer_bench.sv
module jit_pwm_timer_bench;
  localparam int CLK_PERIOD = 10;
  // Expected constants for CLK_HZ = 6 MHz, derived from the requirements
  localparam int P_LO = 100, P_HI = 52;
  localparam int D_LO = 7,   D_HI = 4;
  localparam int S_LO = 1,   S_HI = 1;
  localparam int QUAL = 3; // max(blank 2, min-on 3)

  logic clk = 1'b0;
  logic rst_ni, en_i, trip_i, sel_hi_i, burst_i;
  logic gate_o, start_o, off_o;
  int errors = 0, checks = 0;
  bit done = 0;
  int m_off;
  bit m_up, m_hi;

  always #(CLK_PERIOD/2) clk = ~clk;

  jit_pwm_timer #(.CLK_HZ(6_000_000)) u_jit_pwm_timer (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .trip_i(trip_i),
    .sel_hi_i(sel_hi_i), .burst_i(burst_i), .gate_o(gate_o),
    .start_o(start_o), .off_o(off_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int m_period();
    return (m_hi ? P_HI : P_LO) + m_off;
  endfunction

  function automatic void m_reset();
    m_off = 0;
    m_up  = 1;
  endfunction

  function automatic void m_step();
    int dev = m_hi ? D_HI : D_LO;
    int st  = m_hi ? S_HI : S_LO;
    if (m_up) begin
      if (m_off + st >= dev) begin m_off = dev; m_up = 0; end
      else m_off += st;
    end else begin
      if (m_off - st <= -dev) begin m_off = -dev; m_up = 1; end
      else m_off -= st;
    end
  endfunction

  function automatic int exp_width(input int per, input int d);
    int dl = per * 80 / 100;
    int w  = (d == -1) ? dl : (((d + 2) > QUAL ? (d + 2) : QUAL) + 1);
    return (w < dl) ? w : dl;
  endfunction

  // Precondition: at a negedge where start_o is 1. d>=0 trip pulse, -1 none, -2 held by caller
  task automatic do_cycle(input int d, input string ptag, input string wtag);
    int per = m_period();
    int k = 0, w = 0, offbad = 0, gap = 0;
    bit fell = 0;
    m_step();
    chk("R4 gate high at start", int'(gate_o), 1);
    forever begin
      if (off_o == gate_o) offbad++;
      if (gate_o) begin
        if (fell) gap++;
        w++;
      end else fell = 1;
      if (d >= 0 && k == d) trip_i = 1'b1;
      if (d >= 0 && !gate_o) trip_i = 1'b0;
      @(negedge clk);
      k++;
      if (k == 1 && start_o) gap++;
      if ((k > 1 && start_o) || k > 500) break;
    end
    if (d >= 0) trip_i = 1'b0;
    chk(ptag, k, per);
    chk(wtag, w, exp_width(per, d));
    chk("R4 single start/contiguous gate", gap, 0);
    chk("R11 off marker", offbad, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int d, starts, ghigh;
    void'($urandom(32'd4242));
    rst_ni = 0; en_i = 0; trip_i = 0; sel_hi_i = 0; burst_i = 0;
    m_hi = 0; m_reset();
    repeat (3) @(negedge clk);
    chk("R1 gate in reset", int'(gate_o), 0);
    chk("R1 start in reset", int'(start_o), 0);
    chk("R1 off in reset", int'(off_o), 1);
    rst_ni = 1;
    @(negedge clk);
    en_i = 1;
    @(negedge clk);
    chk("R10 start after enable", int'(start_o), 1);
    do_cycle(-1, "R2 nominal low period", "R5 duty cap");

    // full sweep in low variant with random trip delays
    for (int i = 0; i < 34; i++) begin
      d = ($urandom % 3 == 0) ? -1 : int'($urandom % 31);
      do_cycle(d, "R3 jittered period", (d < 0) ? "R5 duty cap" : "R6 trip width");
    end
    do_cycle(0, "R3 jittered period", "R7 early trip blanked");

    // trip held high across boundary: blanking and min on time
    trip_i = 1'b1;
    do_cycle(-2, "R3 jittered period", "R8 min on with held trip");
    trip_i = 1'b0;
    do_cycle(-1, "R3 jittered period", "R7 stale trip after boundary");

    // burst inhibit
    m_step();
    burst_i = 1'b1;
    starts = 0; ghigh = 0;
    for (int k = 1; k <= 330; k++) begin
      @(negedge clk);
      if (start_o) starts++;
      if (k > 120 && gate_o) ghigh++;
    end
    chk("R9 no start in burst", starts, 0);
    chk("R9 gate low in burst", ghigh, 0);
    burst_i = 1'b0;
    @(negedge clk);
    chk("R9 start after release", int'(start_o), 1);
    do_cycle(-1, "R9 ramp frozen in burst", "R5 duty cap");

    // disable mid pulse, switch to high variant
    en_i = 1'b0;
    @(negedge clk);
    chk("R10 gate low after disable", int'(gate_o), 0);
    starts = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (start_o) starts++;
    end
    chk("R10 no start while disabled", starts, 0);
    sel_hi_i = 1'b1; m_hi = 1; m_reset();
    en_i = 1'b1;
    @(negedge clk);
    chk("R10 start after re-enable", int'(start_o), 1);
    do_cycle(-1, "R2 nominal high period", "R5 duty cap high");
    for (int i = 0; i < 22; i++) begin
      d = ($urandom % 3 == 0) ? -1 : int'($urandom % 20);
      do_cycle(d, "R3 jittered high period", (d < 0) ? "R5 duty cap" : "R6 trip width");
    end
    trip_i = 1'b1;
    do_cycle(-2, "R3 jittered high period", "R8 min on high");
    trip_i = 1'b0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule